// File: doc/BRIEF.md
# RAM-Based Binary Content Addressable Lookup

This block answers the question "which stored entries hold this key?" in a single memory read. It does not compare the key against every stored word. Entries are held transposed. The key is cut into 8-bit slices. Each slice owns a set of 256-row RAM tiles, and every row is a presence vector with one bit per entry. A lookup uses each key slice as a row address, reads one row per slice and ANDs the rows. The result is the per-entry match vector. A priority encoder then picks the lowest matching entry.

Depth grows in groups of 32 entries, with one tile per group per slice. Width grows in 8-bit slices. Each entry also keeps a shadow copy of its key and a valid flag. When an entry is rewritten, the controller can therefore clear the old presence bits before it sets the new ones. After reset, a sweep clears every row before the block accepts any work.

The controller FSM has four states:
- `ST_SWEEP` clears one row per cycle in all tiles. It moves to `ST_IDLE` after the last row.
- `ST_IDLE` waits. An accepted write or erase request moves it to `ST_CLEAR`.
- `ST_CLEAR` removes the entry's old presence bits, if the entry was valid. It moves to `ST_SET` for a write, or back to `ST_IDLE` for an erase.
- `ST_SET` records the new key's presence bits and always returns to `ST_IDLE`.

Top module: `cam_lookup`

## Requirements
- R1: After `rst_n` is released, `busy` stays high for exactly 256 cycles while every row is cleared. A lookup requested in that time produces no result (`lk_valid` stays low). Once `busy` falls, every key misses.
- R2: A lookup requested with `lk_req` at a clock edge gives `lk_valid`, `lk_hit`, `lk_vec` and `lk_addr` after that same edge, for one cycle. In a cycle after no request, `lk_valid`, `lk_hit` and `lk_vec` are all zero.
- R3: A write request (`wr_req` high, `wr_erase` low) accepted while `busy` is low keeps `busy` high for exactly 2 cycles. Afterwards, a lookup of the written key reports the written entry.
- R4: Bit i of `lk_vec` is 1 exactly when entry i is valid and its stored key equals `lk_key` in all bits. Several entries holding the same key are all reported.
- R5: `lk_hit` is the OR of `lk_vec`. On a hit, `lk_addr` is the lowest index whose bit is set. On a miss, `lk_addr` is 0.
- R6: Rewriting a valid entry with a new key removes its match on the old key and adds it on the new key.
- R7: An erase request (`wr_req` and `wr_erase` high) keeps `busy` high for exactly 1 cycle and removes the entry from all matches. Erasing an entry that is not valid has no other effect.
- R8: An entry matches only when every 8-bit key slice matches. A key that shares some slices with a stored key, but not all of them, misses.
- R9: A lookup sampled at the same edge that writes or clears presence bits sees the contents from before that write.
- R10: A `wr_req` seen while `busy` is high is ignored. It neither changes any entry nor lengthens the busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write or erase request, taken only while `busy` is low |
| wr_erase | input | 1 | 1 selects erase, 0 selects write |
| wr_addr | input | ADDR_W (5) | Entry index to write or erase |
| wr_key | input | KEY_W (16) | Key to store in the entry |
| busy | output | 1 | Controller is sweeping or updating an entry |
| lk_req | input | 1 | Lookup request |
| lk_key | input | KEY_W (16) | Key to search for |
| lk_valid | output | 1 | Lookup result is present this cycle |
| lk_hit | output | 1 | At least one entry matched |
| lk_vec | output | ENTRIES (32) | One match bit per entry |
| lk_addr | output | ADDR_W (5) | Lowest matching entry index |

## Verification
All lookup outputs are due in the cycle right after the edge that samples `lk_req`. The bench raises a request at a falling edge and reads the result at the next falling edge, where it also confirms that a request-free cycle returns to zero. The length of the busy period is counted in whole cycles, from the falling edge after the request edge until `busy` is seen low: 2 for a write, 1 for an erase, and 256 for the reset sweep counted from release. To check that a lookup sees the contents from before a write, the bench places lookups in the exact `ST_CLEAR` and `ST_SET` cycles of a rewrite. It compares them with its own entry model before that model is updated.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int unsigned SLICE_W      = 8;
    localparam int unsigned ROWS         = 1 << SLICE_W;
    localparam int unsigned TILE_ENTRIES = 32;
    localparam int unsigned TILE_BIT_W   = $clog2(TILE_ENTRIES);

    typedef enum logic [1:0] {
        ST_SWEEP,
        ST_IDLE,
        ST_CLEAR,
        ST_SET
    } cam_state_e;
endpackage

// File: rtl/cam_tile.sv
module cam_tile
    import cam_pkg::*;
(
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic                    wr_all,
    input  logic [SLICE_W-1:0]      wr_row,
    input  logic [TILE_BIT_W-1:0]   wr_bit,
    input  logic                    wr_val,
    input  logic                    rd_en,
    input  logic [SLICE_W-1:0]      rd_row,
    output logic [TILE_ENTRIES-1:0] rd_vec
);
    timeunit 1ns;
    timeprecision 1ps;

    // one row per slice value, one bit per entry of this group
    logic [TILE_ENTRIES-1:0] rows_q [ROWS];

    // nonblocking read and write in one process: read returns pre-write data
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_all) begin
                rows_q[wr_row] <= '0;
            end else begin
                rows_q[wr_row][wr_bit] <= wr_val;
            end
        end
        if (rd_en) begin
            rd_vec <= rows_q[rd_row];
        end
    end
endmodule

// File: rtl/cam_prienc.sv
module cam_prienc #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0]         vec,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned IDX_W = $clog2(N);

    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import cam_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned KEY_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic                       wr_erase,
    input  logic [$clog2(ENTRIES)-1:0] wr_addr,
    input  logic [KEY_W-1:0]           wr_key,
    output logic                       busy,
    output logic                       sweeping,
    output logic                       mem_wr_en,
    output logic                       mem_wr_all,
    output logic [KEY_W-1:0]           mem_rows,
    output logic [$clog2(ENTRIES)-1:0] mem_entry,
    output logic                       mem_val
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ADDR_W = $clog2(ENTRIES);
    localparam int unsigned SLICES = KEY_W / SLICE_W;

    cam_state_e state, state_nx;

    logic [SLICE_W-1:0] sweep_row;
    logic [ENTRIES-1:0] valid_q;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [ADDR_W-1:0]  cmd_addr;
    logic [KEY_W-1:0]   cmd_key;
    logic               cmd_erase;
    logic [KEY_W-1:0]   old_key;
    logic               old_valid;
    logic               accept;

    assign accept = (state == ST_IDLE) && wr_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SWEEP;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SWEEP: if (sweep_row == SLICE_W'(ROWS - 1)) state_nx = ST_IDLE;
            ST_IDLE:  if (wr_req) state_nx = ST_CLEAR;
            ST_CLEAR: state_nx = cmd_erase ? ST_IDLE : ST_SET;
            ST_SET:   state_nx = ST_IDLE;
            default:  state_nx = ST_SWEEP;
        endcase
    end

    // outputs towards the tiles
    always_comb begin
        mem_wr_en  = 1'b0;
        mem_wr_all = 1'b0;
        mem_rows   = '0;
        mem_entry  = cmd_addr;
        mem_val    = 1'b0;
        unique case (state)
            ST_SWEEP: begin
                mem_wr_en  = 1'b1;
                mem_wr_all = 1'b1;
                mem_rows   = {SLICES{sweep_row}};
            end
            ST_CLEAR: begin
                mem_wr_en = old_valid;
                mem_rows  = old_key;
            end
            ST_SET: begin
                mem_wr_en = 1'b1;
                mem_rows  = cmd_key;
                mem_val   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign sweeping = (state == ST_SWEEP);

    // sweep counter and valid flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_row <= '0;
            valid_q   <= '0;
        end else begin
            if (state == ST_SWEEP) begin
                sweep_row <= sweep_row + 1'b1;
            end
            if (state == ST_CLEAR) begin
                valid_q[cmd_addr] <= !cmd_erase;
            end
        end
    end

    // latched command and shadow keys
    always_ff @(posedge clk) begin
        if (accept) begin
            cmd_addr  <= wr_addr;
            cmd_key   <= wr_key;
            cmd_erase <= wr_erase;
            old_key   <= key_q[wr_addr];
            old_valid <= valid_q[wr_addr];
        end
        if (state == ST_CLEAR && !cmd_erase) begin
            key_q[cmd_addr] <= cmd_key;
        end
    end

    // R1
    sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && sweep_row != SLICE_W'(ROWS - 1)) |=> (state == ST_SWEEP));

    // R3
    write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && !cmd_erase) |=> (state == ST_SET));

    // R7
    erase_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && cmd_erase) |=> (state == ST_IDLE));

    // R10
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR || state == ST_SET) |=> ($stable(cmd_addr) && $stable(cmd_key)));

    // R10
    set_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SET) |=> (state == ST_IDLE));
endmodule

// File: rtl/cam_lookup.sv
module cam_lookup
    import cam_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned KEY_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic                       wr_erase,
    input  logic [$clog2(ENTRIES)-1:0] wr_addr,
    input  logic [KEY_W-1:0]           wr_key,
    output logic                       busy,
    input  logic                       lk_req,
    input  logic [KEY_W-1:0]           lk_key,
    output logic                       lk_valid,
    output logic                       lk_hit,
    output logic [ENTRIES-1:0]         lk_vec,
    output logic [$clog2(ENTRIES)-1:0] lk_addr
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ADDR_W = $clog2(ENTRIES);
    localparam int unsigned SLICES = KEY_W / SLICE_W;
    localparam int unsigned GROUPS = ENTRIES / TILE_ENTRIES;

    logic              sweeping;
    logic              mem_wr_en;
    logic              mem_wr_all;
    logic [KEY_W-1:0]  mem_rows;
    logic [ADDR_W-1:0] mem_entry;
    logic              mem_val;
    logic              rd_en;
    logic [ENTRIES-1:0] slice_vec [SLICES];
    logic [ENTRIES-1:0] and_vec;

    cam_ctrl #(
        .ENTRIES (ENTRIES),
        .KEY_W   (KEY_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_erase   (wr_erase),
        .wr_addr    (wr_addr),
        .wr_key     (wr_key),
        .busy       (busy),
        .sweeping   (sweeping),
        .mem_wr_en  (mem_wr_en),
        .mem_wr_all (mem_wr_all),
        .mem_rows   (mem_rows),
        .mem_entry  (mem_entry),
        .mem_val    (mem_val)
    );

    assign rd_en = lk_req && !sweeping;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        for (genvar g = 0; g < GROUPS; g++) begin : g_group
            logic tile_we;
            assign tile_we = mem_wr_en &&
                (mem_wr_all || ((int'(mem_entry) / TILE_ENTRIES) == g));
            cam_tile u_tile (
                .clk    (clk),
                .wr_en  (tile_we),
                .wr_all (mem_wr_all),
                .wr_row (mem_rows[s*SLICE_W +: SLICE_W]),
                .wr_bit (mem_entry[TILE_BIT_W-1:0]),
                .wr_val (mem_val),
                .rd_en  (rd_en),
                .rd_row (lk_key[s*SLICE_W +: SLICE_W]),
                .rd_vec (slice_vec[s][g*TILE_ENTRIES +: TILE_ENTRIES])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid <= 1'b0;
        end else begin
            lk_valid <= rd_en;
        end
    end

    // an entry matches only when every slice row agrees
    always_comb begin
        and_vec = '1;
        for (int s = 0; s < SLICES; s++) begin
            and_vec &= slice_vec[s];
        end
    end

    assign lk_vec = lk_valid ? and_vec : '0;

    cam_prienc #(
        .N (ENTRIES)
    ) u_enc (
        .vec (lk_vec),
        .hit (lk_hit),
        .idx (lk_addr)
    );

    logic [ENTRIES-1:0] below_mask;
    assign below_mask = (ENTRIES'(1) << lk_addr) - ENTRIES'(1);

    // R1
    sweep_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |=> !lk_valid);

    // R2
    lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !busy) |=> lk_valid);

    // R5
    enc_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_vec[lk_addr]);

    // R5
    enc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_vec & below_mask) == '0));

    // R5
    miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_addr == '0));
endmodule

// File: tb/tb_cam_lookup.sv
module tb_cam_lookup;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ENTRIES = 32;
    localparam int KEY_W   = 16;
    localparam int ADDR_W  = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_req = 1'b0;
    logic               wr_erase = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [KEY_W-1:0]   wr_key = '0;
    logic               busy;
    logic               lk_req = 1'b0;
    logic [KEY_W-1:0]   lk_key = '0;
    logic               lk_valid;
    logic               lk_hit;
    logic [ENTRIES-1:0] lk_vec;
    logic [ADDR_W-1:0]  lk_addr;

    int checks = 0;
    int errors = 0;

    logic [KEY_W-1:0] m_key [ENTRIES];
    bit               m_val [ENTRIES];

    cam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_erase(wr_erase),
        .wr_addr(wr_addr), .wr_key(wr_key), .busy(busy), .lk_req(lk_req),
        .lk_key(lk_key), .lk_valid(lk_valid), .lk_hit(lk_hit),
        .lk_vec(lk_vec), .lk_addr(lk_addr)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ENTRIES-1:0] model_vec(input logic [KEY_W-1:0] key);
        logic [ENTRIES-1:0] v = '0;
        for (int i = 0; i < ENTRIES; i++) v[i] = m_val[i] && (m_key[i] == key);
        return v;
    endfunction

    function automatic int lowest(input logic [ENTRIES-1:0] v);
        for (int i = 0; i < ENTRIES; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check_result(input logic [ENTRIES-1:0] ev, input string req);
        chk(lk_valid == 1'b1, req, "lk_valid", lk_valid, 1);
        chk(lk_vec == ev, req, "lk_vec", lk_vec, ev);
        chk(lk_hit == (ev != 0), req, "lk_hit", lk_hit, ev != 0);
        chk(lk_addr == ADDR_W'(lowest(ev)), req, "lk_addr", lk_addr, lowest(ev));
    endtask

    // starts and ends at a falling edge
    task automatic lookup_check(input logic [KEY_W-1:0] key, input string req);
        lk_req = 1'b1;
        lk_key = key;
        @(negedge clk);
        lk_req = 1'b0;
        check_result(model_vec(key), req);
    endtask

    task automatic write_cmd(input int addr, input logic [KEY_W-1:0] key,
                             input bit erase, input int exp_busy, input string req);
        int cnt = 0;
        wr_req = 1'b1; wr_erase = erase; wr_addr = ADDR_W'(addr); wr_key = key;
        @(negedge clk);
        wr_req = 1'b0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp_busy, req, "busy cycles", cnt, exp_busy);
        if (erase) m_val[addr] = 1'b0;
        else begin m_val[addr] = 1'b1; m_key[addr] = key; end
    endtask

    task automatic t_reset_sweep;
        int cnt = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
        chk(lk_valid == 1'b0, "R2", "lk_valid in reset", lk_valid, 0);
        rst_n = 1'b1;
        while (busy && cnt < 1000) begin
            if (cnt == 5) begin lk_req = 1'b1; lk_key = '0; end
            if (cnt == 6) begin
                lk_req = 1'b0;
                chk(lk_valid == 1'b0, "R1", "lookup during sweep", lk_valid, 0);
            end
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 256, "R1", "sweep length", cnt, 256);
        lookup_check(16'h0000, "R1");
        lookup_check(16'hFFFF, "R1");
    endtask

    task automatic t_basic_write;
        write_cmd(5, 16'h1234, 1'b0, 2, "R3");
        lookup_check(16'h1234, "R3");
        write_cmd(9, 16'h1234, 1'b0, 2, "R3");
        lookup_check(16'h1234, "R4");
        write_cmd(2, 16'h1234, 1'b0, 2, "R3");
        lookup_check(16'h1234, "R5");
    endtask

    task automatic t_slices;
        write_cmd(7, 16'h12AB, 1'b0, 2, "R3");
        lookup_check(16'h1234, "R8");
        lookup_check(16'h12AB, "R8");
        lookup_check(16'h1235, "R8");
        lookup_check(16'h3434, "R8");
    endtask

    task automatic t_overwrite;
        write_cmd(5, 16'hBEEF, 1'b0, 2, "R6");
        lookup_check(16'h1234, "R6");
        lookup_check(16'hBEEF, "R6");
    endtask

    task automatic t_erase;
        write_cmd(9, 16'h0000, 1'b1, 1, "R7");
        lookup_check(16'h1234, "R7");
        write_cmd(11, 16'h0000, 1'b1, 1, "R7");
        lookup_check(16'h0000, "R7");
    endtask

    task automatic t_busy_ignore;
        wr_req = 1'b1; wr_erase = 1'b0; wr_addr = 5'd20; wr_key = 16'h5555;
        @(negedge clk);
        wr_addr = 5'd21; wr_key = 16'h6666;
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10", "busy not extended", busy, 0);
        m_val[20] = 1'b1; m_key[20] = 16'h5555;
        lookup_check(16'h6666, "R10");
        lookup_check(16'h5555, "R10");
    endtask

    task automatic t_pre_write;
        wr_req = 1'b1; wr_erase = 1'b0; wr_addr = 5'd2; wr_key = 16'h0F0F;
        @(negedge clk);
        wr_req = 1'b0;
        lk_req = 1'b1; lk_key = 16'h1234;
        @(negedge clk);
        check_result(model_vec(16'h1234), "R9");
        lk_key = 16'h0F0F;
        @(negedge clk);
        lk_req = 1'b0;
        check_result(model_vec(16'h0F0F), "R9");
        m_key[2] = 16'h0F0F;
        lookup_check(16'h0F0F, "R9");
        lookup_check(16'h1234, "R6");
    endtask

    task automatic t_edges;
        write_cmd(31, 16'hFFFF, 1'b0, 2, "R3");
        lookup_check(16'hFFFF, "R5");
        write_cmd(0, 16'hFFFF, 1'b0, 2, "R3");
        lookup_check(16'hFFFF, "R5");
    endtask

    task automatic t_idle_out;
        lookup_check(16'hBEEF, "R2");
        @(negedge clk);
        chk(lk_valid == 1'b0, "R2", "lk_valid idle", lk_valid, 0);
        chk(lk_hit == 1'b0, "R2", "lk_hit idle", lk_hit, 0);
        chk(lk_vec == '0, "R2", "lk_vec idle", lk_vec, 0);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_key[i] = '0; m_val[i] = 1'b0; end
        @(negedge clk);
        t_reset_sweep();
        t_basic_write();
        t_slices();
        t_overwrite();
        t_erase();
        t_busy_ignore();
        t_pre_write();
        t_edges();
        t_idle_out();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule